// File: doc/BRIEF.md
# Watch Timer with Tone Output

This block is a free-running binary divider, clocked by the system clock, for a clock near 4.19 MHz (nominally 4,194,304 Hz). Two taps of the one divider serve two jobs. A slow tap raises an interval request every 2^21 clocks (0.5 s) or every 2^14 clocks (about 3.91 ms). A fast tap drives a square-wave tone pin at the clock divided by 2048, 1024, 512 or 256, which gives 2, 4, 8 or 16 kHz.

Software sets the block up by writing a mode register over a small register bus with a one-bit address. The interval request sets a sticky flag that has no vector of its own. Software polls the flag through the same bus and clears it by writing zero. A one-cycle tick output marks each interval event for logic that wants an edge. The tap positions are parameters, so a scaled-down instance keeps the same behaviour with shorter periods.

Top module: `watch_buzz_timer`

## Requirements
- R1: After reset the mode register reads 0x00, the request flag is 0, the tick is 0 and the tone pin is low.
- R2: A write to address 0 loads the mode register: bit 0 run, bit 1 short interval, bits 3:2 tone select, bit 4 tone enable. A read of address 0 returns these five bits, with bits 7:5 reading zero.
- R3: With run set and the short-interval bit clear, the first interval event comes 2^LONG_LOG2 clocks after the enabling write edge, and later events follow every 2^LONG_LOG2 clocks.
- R4: With run set and the short-interval bit set, interval events come every 2^SHORT_LOG2 clocks, the first one 2^SHORT_LOG2 clocks after the enabling write edge.
- R5: With run and tone enable set, the tone pin is a square wave with period 2^(BUZ_BASE_LOG2+3-sel) clocks and 50% duty. Select 0 gives the slowest tone and select 3 the fastest.
- R6: The tone pin stays low while tone enable or run is clear.
- R7: Clearing run resets the divider to zero. After run is set again, the next interval event needs the full period, measured from the new enabling write.
- R8: An interval event sets the request flag, which reads back as bit 0 at address 1. The flag stays set until a write to address 1 with bit 0 equal to 0. A write with bit 0 equal to 1 has no effect.
- R9: When an interval event and a clearing write fall on the same clock edge, the flag ends up set.
- R10: The tick output is high for exactly one clock on each interval event, on the same edge that sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 1 | Register select: 0 mode, 1 request flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| wt_tick | output | 1 | One-cycle pulse on each interval event |
| wt_flag | output | 1 | Sticky interval request flag |
| buz_o | output | 1 | Tone square wave |

## Verification
Cycles are counted from the clock edge that takes a write. The first interval tick and the flag both appear exactly 2^N edges later, and every later tick follows 2^N edges after the one before. The bench keeps a count of rising edges and samples on falling edges, so each event time it records is an exact edge index, and it compares the difference with the period computed from the parameters. A clear is timed to land on the very edge of a predicted event, and read data is checked one nanosecond after the address changes, since the read path has no register. Tone period and high time are measured from rise to fall to rise on the pin, and the one-register delay on the pin cancels out of both figures.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

   localparam int MODE_W = 5;

   typedef struct packed {
      logic       tone_en;   // bit 4
      logic [1:0] tone_sel;  // bits 3:2
      logic       short_iv;  // bit 1
      logic       run;       // bit 0
   } wbt_mode_t;

   localparam logic ADDR_MODE = 1'b0;
   localparam logic ADDR_FLAG = 1'b1;

endpackage

// File: rtl/wbt_regs.sv
module wbt_regs
   import wbt_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic            addr,
   input  logic [7:0]      wdata,
   input  logic            iv_event,
   output wbt_mode_t       mode,
   output logic            flag,
   output logic            tick,
   output logic [7:0]      rdata
);

   logic clr_req;

   assign clr_req = wr && (addr == ADDR_FLAG) && !wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (wr && (addr == ADDR_MODE)) begin
         mode <= wbt_mode_t'(wdata[MODE_W-1:0]);
      end
   end

   // an event on the same edge as a clear keeps the flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         tick <= 1'b0;
      end else begin
         tick <= iv_event;
         if (iv_event)     flag <= 1'b1;
         else if (clr_req) flag <= 1'b0;
      end
   end

   always_comb begin
      if (addr == ADDR_MODE) rdata = {{(8-MODE_W){1'b0}}, mode};
      else                   rdata = {7'b0, flag};
   end

endmodule

// File: rtl/wbt_divider.sv
module wbt_divider #(
   parameter int LONG_LOG2  = 21,
   parameter int SHORT_LOG2 = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 short_iv,
   output logic [LONG_LOG2-1:0] cnt,
   output logic                 iv_event
);

   logic long_hit;
   logic short_hit;

   generate
      if (SHORT_LOG2 < 1 || SHORT_LOG2 >= LONG_LOG2) begin : g_bad
         $error("wbt_divider: need 1 <= SHORT_LOG2 < LONG_LOG2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (!run) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   assign long_hit  = &cnt;
   assign short_hit = &cnt[SHORT_LOG2-1:0];
   assign iv_event  = run && (short_iv ? short_hit : long_hit);

endmodule

// File: rtl/wbt_tone.sv
module wbt_tone #(
   parameter int CNT_W         = 21,
   parameter int BUZ_BASE_LOG2 = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             run,
   input  logic             tone_en,
   input  logic [1:0]       tone_sel,
   output logic             buz
);

   localparam int NTAP = 4;
   logic [NTAP-1:0] taps;

   generate
      if (BUZ_BASE_LOG2 < 1 || BUZ_BASE_LOG2 + NTAP - 1 > CNT_W) begin : g_bad
         $error("wbt_tone: tone taps fall outside the divider");
      end
      for (genvar g = 0; g < NTAP; g++) begin : g_tap
         // select g: half period 2^(BASE-1+3-g) clocks
         assign taps[g] = cnt[BUZ_BASE_LOG2 - 1 + (NTAP - 1 - g)];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buz <= 1'b0;
      else        buz <= run && tone_en && taps[tone_sel];
   end

endmodule

// File: rtl/watch_buzz_timer.sv
module watch_buzz_timer
   import wbt_pkg::*;
#(
   parameter int LONG_LOG2     = 21,
   parameter int SHORT_LOG2    = 14,
   parameter int BUZ_BASE_LOG2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       wt_tick,
   output logic       wt_flag,
   output logic       buz_o
);

   wbt_mode_t            mode_q;
   logic [LONG_LOG2-1:0] div_cnt;
   logic                 iv_event;
   logic                 run_w;

   assign run_w = mode_q.run;

   wbt_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .iv_event (iv_event),
      .mode     (mode_q),
      .flag     (wt_flag),
      .tick     (wt_tick),
      .rdata    (bus_rdata)
   );

   wbt_divider #(
      .LONG_LOG2  (LONG_LOG2),
      .SHORT_LOG2 (SHORT_LOG2)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_w),
      .short_iv (mode_q.short_iv),
      .cnt      (div_cnt),
      .iv_event (iv_event)
   );

   wbt_tone #(
      .CNT_W         (LONG_LOG2),
      .BUZ_BASE_LOG2 (BUZ_BASE_LOG2)
   ) u_tone (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (div_cnt),
      .run      (run_w),
      .tone_en  (mode_q.tone_en),
      .tone_sel (mode_q.tone_sel),
      .buz      (buz_o)
   );

endmodule

// File: rtl/wbt_checker.sv
module wbt_checker #(
   parameter int CNT_W = 21
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_addr,
   input logic [7:0]       bus_wdata,
   input logic             wt_tick,
   input logic             wt_flag,
   input logic             buz_o,
   input logic             run,
   input logic [CNT_W-1:0] cnt
);

   AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wt_tick |-> wt_flag); // R10

   AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wt_tick |=> !wt_tick); // R10

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wt_flag && !(bus_wr && bus_addr && !bus_wdata[0])) |=> wt_flag); // R8

   AST_FLAG_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wt_flag) |-> wt_tick); // R8

   AST_TONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !buz_o); // R6

   AST_DIV_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0)); // R7

endmodule

bind watch_buzz_timer wbt_checker #(.CNT_W(LONG_LOG2)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .wt_tick   (wt_tick),
   .wt_flag   (wt_flag),
   .buz_o     (buz_o),
   .run       (run_w),
   .cnt       (div_cnt)
);

// File: tb/tb_watch_buzz_timer.sv
`timescale 1ns/1ps
module tb_watch_buzz_timer;

   localparam int LONG_L  = 13;
   localparam int SHORT_L = 9;
   localparam int BASE_L  = 4;
   localparam int WD      = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       wt_tick, wt_flag, buz_o;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   watch_buzz_timer #(
      .LONG_LOG2     (LONG_L),
      .SHORT_LOG2    (SHORT_L),
      .BUZ_BASE_LOG2 (BASE_L)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wt_tick   (wt_tick),
      .wt_flag   (wt_flag),
      .buz_o     (buz_o)
   );

   function automatic int exp_interval(input bit short_sel);
      return short_sel ? (1 << SHORT_L) : (1 << LONG_L);
   endfunction

   function automatic int exp_tone_period(input int sel);
      return 1 << (BASE_L + 3 - sel);
   endfunction

   function automatic logic [7:0] mode_word(input bit run, input bit shrt,
                                            input int sel, input bit ten);
      return {3'b000, ten, sel[1:0], shrt, run};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic do_write(input logic a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic do_read(input logic a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_tick(output int t);
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!wt_tick && guard < 20000);
      t = cyc;
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic wait_buz(input logic v);
      int guard = 0;
      while (buz_o !== v && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic measure_tone(input int sel);
      int r1, f1, r2;
      wait_buz(1'b0);
      wait_buz(1'b1); r1 = cyc;
      wait_buz(1'b0); f1 = cyc;
      wait_buz(1'b1); r2 = cyc;
      check((r2 - r1) == exp_tone_period(sel), "R5 tone period", r2 - r1, exp_tone_period(sel));
      check((f1 - r1) == exp_tone_period(sel) / 2, "R5 tone high time", f1 - r1, exp_tone_period(sel) / 2);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      int w, t, t2, seed_v, k;
      bit lowseen;
      seed_v = $urandom(32'h5EED_0042);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      do_read(1'b0, rd); check(rd == 8'h00, "R1 mode after reset", rd, 0);
      do_read(1'b1, rd); check(rd == 8'h00, "R1 flag read after reset", rd, 0);
      check(wt_flag == 1'b0 && wt_tick == 1'b0, "R1 flag/tick low", wt_flag, 0);
      check(buz_o == 1'b0, "R1 tone low", buz_o, 0);

      // R2 mode readback with random data, run kept clear
      for (int i = 0; i < 4; i++) begin
         logic [7:0] d;
         d = 8'($urandom) & 8'hFE;
         @(negedge clk);
         do_write(1'b0, d);
         do_read(1'b0, rd);
         check(rd == (d & 8'h1F), "R2 mode readback", rd, d & 8'h1F);
      end
      do_write(1'b0, 8'h00);

      // R4 short interval, R10 tick width, R8 flag set
      do_write(1'b0, mode_word(1, 1, 0, 0)); w = cyc;
      wait_tick(t);
      check((t - w) == exp_interval(1), "R4 first short event", t - w, exp_interval(1));
      check(wt_flag == 1'b1, "R8 flag set by event", wt_flag, 1);
      @(negedge clk);
      check(wt_tick == 1'b0, "R10 tick one cycle", wt_tick, 0);
      do_read(1'b1, rd); check(rd == 8'h01, "R8 flag readback", rd, 1);
      wait_tick(t2);
      check((t2 - t) == exp_interval(1), "R4 repeat short event", t2 - t, exp_interval(1));

      // R8 write 1 ignored, write 0 clears
      @(negedge clk);
      do_write(1'b1, 8'hFF);
      check(wt_flag == 1'b1, "R8 write one no effect", wt_flag, 1);
      repeat ($urandom % 50) @(negedge clk);
      do_write(1'b1, 8'h00);
      check(wt_flag == 1'b0, "R8 clear by zero", wt_flag, 0);
      do_read(1'b1, rd); check(rd == 8'h00, "R8 cleared readback", rd, 0);

      // R9 clear on the event edge
      wait_until(t2 + 2 * exp_interval(1) - 1);
      do_write(1'b1, 8'h00);
      check(cyc == t2 + 2 * exp_interval(1), "R9 timing alignment", cyc, t2 + 2 * exp_interval(1));
      check(wt_tick == 1'b1, "R9 event on clear edge", wt_tick, 1);
      check(wt_flag == 1'b1, "R9 event wins over clear", wt_flag, 1);
      @(negedge clk);
      do_write(1'b1, 8'h00);

      // R7 mid-count restart
      k = 1 + ($urandom % (exp_interval(1) - 2));
      repeat (k) @(negedge clk);
      do_write(1'b0, 8'h00);
      repeat (5) @(negedge clk);
      check(wt_tick == 1'b0 && buz_o == 1'b0, "R7 idle after stop", buz_o, 0);
      do_write(1'b0, mode_word(1, 1, 0, 0)); w = cyc;
      wait_tick(t);
      check((t - w) == exp_interval(1), "R7 full period after restart", t - w, exp_interval(1));
      do_write(1'b0, 8'h00);
      do_write(1'b1, 8'h00);

      // R3 long interval
      do_write(1'b0, mode_word(1, 0, 0, 0)); w = cyc;
      wait_tick(t);
      check((t - w) == exp_interval(0), "R3 first long event", t - w, exp_interval(0));
      wait_tick(t2);
      check((t2 - t) == exp_interval(0), "R3 repeat long event", t2 - t, exp_interval(0));
      do_write(1'b0, 8'h00);
      do_write(1'b1, 8'h00);

      // R5 every tone select, random order
      k = $urandom % 4;
      for (int i = 0; i < 4; i++) begin
         int s;
         s = (k + i) % 4;
         do_write(1'b0, mode_word(1, 0, s, 1));
         repeat ($urandom % 20) @(negedge clk);
         measure_tone(s);
      end

      // R6 tone enable clear, then run clear
      do_write(1'b0, mode_word(1, 0, 3, 0));
      @(negedge clk);
      lowseen = 1'b1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (buz_o) lowseen = 1'b0;
      end
      check(lowseen, "R6 tone off with enable clear", !lowseen, 0);
      do_write(1'b0, mode_word(0, 0, 3, 1));
      @(negedge clk);
      lowseen = 1'b1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (buz_o) lowseen = 1'b0;
      end
      check(lowseen, "R6 tone off with run clear", !lowseen, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule